// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire Serial Bus

This block lets an external bus master read and write a small bank of byte-wide configuration registers over a two-wire serial bus. SCL and SDA arrive as asynchronous pins and are oversampled by the system clock. The block answers on SDA only through an open-drain enable: when `sda_oe` is high, the pad pulls the line low. A register pointer selects the target register. In a write transfer, the first data byte loads the pointer and every later byte writes one register. A read transfer returns bytes starting at the current pointer. The pointer advances after every data byte in both directions.

The bus-facing logic is isolated whenever the block is not taking part in a transfer. This applies after a STOP, after an address byte that names another device, and after the master refuses a byte it has read. In each of these cases SCL edges are ignored until the next START. A separate undervoltage reset input reloads every register with its default value without disturbing the bus state machine.

Top module: `i2c_cfg_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) begins reception of an address byte from any state, including in the middle of a transfer (repeated START), and no STOP is needed first.
- R2: A STOP (SDA rising while SCL is high) ends the transfer: `sda_oe` goes low and later SCL edges are ignored until a START.
- R3: The address byte is seven address bits sent MSB first, followed by a direction bit (1 = read, 0 = write). When the seven bits equal `SLV_ADDR`, the block holds `sda_oe` high throughout the ninth clock.
- R4: After an address byte that does not match, the block gives no acknowledge and ignores all SCL activity until the next START. It asserts no `sda_oe` and changes no register, even for later bytes that carry its own address.
- R5: In a write transfer, the first data byte loads the pointer from its low log2(NREG) bits. Every received data byte is acknowledged on its ninth clock.
- R6: Each write data byte after the first is stored in the register at the pointer, and the pointer then increments, wrapping from NREG-1 to 0. There is no limit on the number of bytes.
- R7: In a read transfer, the block sends the register at the pointer MSB first and increments the pointer after each byte. It changes `sda_oe` only in the cycle after a detected SCL fall. A master acknowledge (SDA low on the ninth clock) starts the next byte.
- R8: When the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next START.
- R9: Asserting `uv_rst` reloads every register with its field of `RST_VAL` (register i in bits 8i+7..8i) and clears the pointer at the next clock. This takes priority over a write in the same cycle.
- R10: While `rst_n` is low, the registers hold their defaults, `sda_oe` is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_rst | input | 1 | Synchronous undervoltage reset that reloads register defaults |
| scl_i | input | 1 | Bus clock pin, asynchronous |
| sda_i | input | 1 | Bus data pin, asynchronous |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| cfg_q | output | NREG*8 | Register contents, register i in bits 8i+7..8i |

## Verification
The hardest condition to reach is the isolated state in which the bus keeps toggling. To show the isolation works, the bench must present bytes that a non-isolated slave would acknowledge, and it must do so without a START. After a mismatched address and again after a STOP, the stimulus clocks out the block's own write address followed by a pointer and data. The bench then confirms that `sda_oe` never rises and that `cfg_q` is unchanged. Reaching the NACK case requires a repeated START that turns a pointer-setting write into a read. The master then refuses the last byte and keeps clocking.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,   // isolated: SCL edges ignored
    ST_ADDR,   // shifting in address byte
    ST_AACK,   // acknowledging own address
    ST_RX,     // shifting in a write byte
    ST_RACK,   // acknowledging a write byte
    ST_TX,     // shifting out a read byte
    ST_MACK    // waiting for master acknowledge
  } xfer_st_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] scl_pipe;
  logic [PIPE_W-1:0] sda_pipe;
  logic scl_now, scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
      sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
    end
  end

  assign scl_now  = scl_pipe[SYNC_STAGES-1];
  assign scl_prev = scl_pipe[SYNC_STAGES];
  assign sda_s    = sda_pipe[SYNC_STAGES-1];
  assign sda_prev = sda_pipe[SYNC_STAGES];

  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
  parameter int NREG = 4,
  parameter logic [NREG*8-1:0] RST_VAL = '0,
  localparam int PW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uv_rst,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_idx,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] regs_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            q <= RST_VAL[g*8 +: 8];
      else if (uv_rst)                       q <= RST_VAL[g*8 +: 8];
      else if (wr_en && wr_idx == PW'(g))    q <= wr_data;
    end
    assign regs_flat[g*8 +: 8] = q;
  end
endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h3A,
  parameter int NREG = 4,
  localparam int PW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uv_rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [NREG*8-1:0] regs_flat,
  output logic              sda_oe,
  output logic              active,
  output logic              wr_en,
  output logic [PW-1:0]     wr_idx,
  output logic [7:0]        wr_data
);
  xfer_st_t             state;
  logic [BIT_CNT_W-1:0] bitcnt;
  logic [7:0]           shreg, txsh, rd_byte;
  logic [PW-1:0]        ptr, ptr_inc;
  logic                 rw, first, macked;
  logic                 byte_end;

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NREG; i++)
      if (ptr == PW'(i)) rd_byte = regs_flat[i*8 +: 8];
  end

  assign ptr_inc  = (ptr == PW'(NREG-1)) ? '0 : ptr + PW'(1);
  assign byte_end = scl_fall && (bitcnt == BIT_CNT_W'(8));
  assign wr_en    = (state == ST_RX) && byte_end && !first && !start_det && !stop_det;
  assign wr_idx   = ptr;
  assign wr_data  = shreg;
  assign active   = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txsh   <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      first  <= 1'b0;
      macked <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + BIT_CNT_W'(1);
            end else if (byte_end) begin
              if (shreg[7:1] == SLV_ADDR) begin
                rw     <= shreg[0];
                sda_oe <= 1'b1;
                state  <= ST_AACK;
              end else begin
                state  <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              first  <= 1'b1;
              if (rw) begin
                txsh   <= rd_byte;
                sda_oe <= ~rd_byte[7];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + BIT_CNT_W'(1);
            end else if (byte_end) begin
              ptr    <= first ? shreg[PW-1:0] : ptr_inc;
              first  <= 1'b0;
              sda_oe <= 1'b1;
              state  <= ST_RACK;
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + BIT_CNT_W'(1);
            end else if (byte_end) begin
              sda_oe <= 1'b0;
              ptr    <= ptr_inc;
              state  <= ST_MACK;
            end else if (scl_fall && bitcnt != '0) begin
              txsh   <= {txsh[6:0], 1'b0};
              sda_oe <= ~txsh[6];
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              macked <= ~sda_s;
            end else if (scl_fall) begin
              if (macked) begin
                txsh   <= rd_byte;
                sda_oe <= ~rd_byte[7];
                bitcnt <= '0;
                state  <= ST_TX;
              end else begin
                state  <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
      if (uv_rst) ptr <= '0;
    end
  end
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h3A,
  parameter int NREG = 4,
  parameter logic [NREG*8-1:0] RST_VAL = 32'h5A3C_1E00,
  localparam int PW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uv_rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_q
);
  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          active, wr_en;
  logic [PW-1:0] wr_idx;
  logic [7:0]    wr_data;

  i2c_line_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_xfer_fsm #(.SLV_ADDR(SLV_ADDR), .NREG(NREG)) u_fsm (
    .clk(clk), .rst_n(rst_n), .uv_rst(uv_rst), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .regs_flat(cfg_q), .sda_oe(sda_oe), .active(active),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  cfg_regbank #(.NREG(NREG), .RST_VAL(RST_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .uv_rst(uv_rst), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .regs_flat(cfg_q)
  );
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk #(
  parameter int NREG = 4,
  parameter logic [NREG*8-1:0] RST_VAL = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              uv_rst,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input logic              active,
  input logic              sda_oe,
  input logic [NREG*8-1:0] cfg_q
);
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> active);  // R1
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!active && !sda_oe));  // R2
  AST_ISOLATED_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sda_oe);  // R4
  AST_DRIVE_AFTER_SCL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall));  // R7
  AST_UV_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    uv_rst |=> (cfg_q == RST_VAL));  // R9
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(.NREG(NREG), .RST_VAL(RST_VAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .uv_rst(uv_rst), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .active(active),
  .sda_oe(sda_oe), .cfg_q(cfg_q)
);

// File: tb/i2c_cfg_slave_tb.sv
module i2c_cfg_slave_tb;
  localparam logic [6:0]  SLV  = 7'h3A;
  localparam int          NREG = 4;
  localparam logic [31:0] DEF  = 32'h5A3C_1E00;
  localparam int          Q    = 10;
  localparam logic [7:0]  AW   = {SLV, 1'b0};
  localparam logic [7:0]  AR   = {SLV, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, uv_rst = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  wire  sda_oe;
  wire  [NREG*8-1:0] cfg_q;
  wire  sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_cfg_slave #(.SLV_ADDR(SLV), .NREG(NREG), .RST_VAL(DEF)) u_dut (
    .clk(clk), .rst_n(rst_n), .uv_rst(uv_rst), .scl_i(scl_m),
    .sda_i(sda_line), .sda_oe(sda_oe), .cfg_q(cfg_q)
  );

  int   checks = 0, fails = 0;
  bit   done = 0, watch = 0, oe_seen = 0;
  logic [7:0] exp_r [NREG];

  always @(negedge clk) if (watch && sda_oe) oe_seen = 1;

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_flat();
    logic [31:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = exp_r[i];
    return v;
  endfunction

  task automatic bus_start();
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask
  task automatic bus_stop();
    sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
  endtask
  task automatic scl_pulse();
    wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
    end
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); ack = ~sda_line; wq(Q); scl_m = 0; wq(Q);
  endtask
  task automatic recv_byte(input bit ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1; wq(Q); b[i] = sda_line; wq(Q); scl_m = 0;
    end
    sda_m = ~ack; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q); sda_m = 1;
  endtask

  task automatic t_reset();
    chk(cfg_q == DEF, "R10 defaults", cfg_q, DEF);
    chk(sda_oe == 0, "R10 sda released", 32'(sda_oe), 0);
  endtask

  task automatic t_write_burst();
    bit a;
    logic [7:0] d [4] = '{8'hAA, 8'hBB, 8'hCC, 8'hDD};
    bus_start();
    send_byte(AW, a);   chk(a, "R3 address ack", 32'(a), 1);
    send_byte(8'h01, a); chk(a, "R5 pointer byte ack", 32'(a), 1);
    for (int i = 0; i < 4; i++) begin
      send_byte(d[i], a); chk(a, "R5 data ack", 32'(a), 1);
      exp_r[(1 + i) % NREG] = d[i];
    end
    bus_stop();
    chk(cfg_q == exp_flat(), "R6 burst write with wrap", cfg_q, exp_flat());
    wq(4);
    chk(sda_oe == 0, "R2 released after stop", 32'(sda_oe), 0);
  endtask

  task automatic t_read_restart();
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(AW, a);    chk(a, "R3 address ack", 32'(a), 1);
    send_byte(8'h02, a); chk(a, "R5 pointer ack", 32'(a), 1);
    bus_start();
    send_byte(AR, a);    chk(a, "R1 repeated start read address ack", 32'(a), 1);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, b);
      chk(b == exp_r[(2 + i) % NREG], "R7 read data", 32'(b), 32'(exp_r[(2 + i) % NREG]));
    end
    oe_seen = 0; watch = 1;
    for (int i = 0; i < 9; i++) scl_pulse();
    watch = 0;
    chk(!oe_seen, "R8 silent after master nack", 32'(oe_seen), 0);
    bus_stop();
  endtask

  task automatic t_mismatch();
    bit a;
    bus_start();
    send_byte({SLV ^ 7'h01, 1'b0}, a);
    chk(!a, "R4 no ack on foreign address", 32'(a), 0);
    oe_seen = 0; watch = 1;
    send_byte(AW, a);    chk(!a, "R4 own address ignored while isolated", 32'(a), 0);
    send_byte(8'h00, a); chk(!a, "R4 pointer ignored", 32'(a), 0);
    send_byte(8'h55, a); chk(!a, "R4 data ignored", 32'(a), 0);
    watch = 0;
    chk(!oe_seen, "R4 no drive while isolated", 32'(oe_seen), 0);
    bus_stop();
    chk(cfg_q == exp_flat(), "R4 registers untouched", cfg_q, exp_flat());
  endtask

  task automatic t_after_stop();
    bit a;
    wq(Q); scl_m = 0; wq(Q);
    oe_seen = 0; watch = 1;
    send_byte(AW, a);    chk(!a, "R2 no ack after stop", 32'(a), 0);
    send_byte(8'h01, a);
    send_byte(8'h99, a);
    watch = 0;
    chk(!oe_seen, "R2 no drive after stop", 32'(oe_seen), 0);
    bus_stop();
    chk(cfg_q == exp_flat(), "R2 registers untouched after stop", cfg_q, exp_flat());
  endtask

  task automatic t_undervoltage();
    bit a;
    logic [7:0] b;
    @(negedge clk); uv_rst = 1; @(negedge clk); uv_rst = 0;
    chk(cfg_q == DEF, "R9 defaults reloaded", cfg_q, DEF);
    for (int i = 0; i < NREG; i++) exp_r[i] = DEF[i*8 +: 8];
    bus_start();
    send_byte(AR, a); chk(a, "R3 read address ack", 32'(a), 1);
    recv_byte(1'b0, b);
    chk(b == DEF[7:0], "R9 pointer cleared", 32'(b), 32'(DEF[7:0]));
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) exp_r[i] = DEF[i*8 +: 8];
    wq(5);
    t_reset();
    rst_n = 1;
    wq(5);
    t_write_burst();
    t_read_restart();
    t_mismatch();
    t_after_stop();
    t_undervoltage();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule